// File: doc/BRIEF.md
# ISA I/O Read Cycle Initiator

This block acts as owner of an ISA-style expansion bus and runs I/O read cycles for a local requester. The requester presents a 16-bit I/O address and a one-clock start pulse. The block then steps through four phases. In the address phase it drives the address with the latch strobe high. In the command phase it holds the read strobe low. The slave may extend this with a wait phase. A recovery phase follows. The block returns the captured read data together with a single-clock done pulse.

A cycle can also be flagged as a DMA or refresh cycle with a mode input. Such a cycle sets the address-enable line high for its whole length, so that ordinary I/O slaves do not decode it. It also keeps the latch strobe high from the address phase to the end of recovery. The slave's 16-bit-capable line is sampled together with the data. When that line is inactive, only the low byte is returned. The bus outputs have a separate enable that stays low while reset is held.

Top module: `isa_io_reader`

## Requirements
- R1: While rst_n is low, isa_oe is 0. After reset, with no request, isa_oe is 1, isa_aen is 0, isa_bale is 0, isa_ior_n is 1 and rd_done is 0.
- R2: In a cycle with req_dma=0, isa_bale is high for exactly ADDR_CLKS clocks, directly before isa_ior_n falls. isa_sa equals the requested address for the whole time isa_bale is high or isa_ior_n is low.
- R3: isa_aen stays 0 throughout a cycle requested with req_dma=0, and stays 1 throughout a cycle requested with req_dma=1.
- R4: In a cycle requested with req_dma=1, isa_bale stays high for ADDR_CLKS + (clocks isa_ior_n is low) + RECOV_CLKS consecutive clocks.
- R5: isa_ior_n is low for at least CMD_CLKS clocks. It stays low through every clock edge at which isa_iochrdy is sampled 0. It rises only after an edge at which isa_iochrdy is sampled 1 once the minimum has elapsed.
- R6: isa_sd is captured at the last clock edge at which isa_ior_n is low. In the clock after that edge, rd_done is 1 for exactly one clock and rd_data holds the captured value.
- R7: When isa_iocs16_n is sampled 0 with the data, rd_data is the full isa_sd. When it is sampled 1, rd_data[7:0] is isa_sd[7:0] and rd_data[15:8] is 0.
- R8: A req_start sampled while a cycle is in progress is ignored. This covers the clock in which rd_done is 1 and the whole recovery phase. No second latch strobe or done pulse follows, and isa_sa does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-clock request to begin a cycle |
| req_addr | input | 16 | I/O address for the requested cycle |
| req_dma | input | 1 | 1 marks the cycle as DMA or refresh |
| rd_data | output | 16 | Captured read data |
| rd_done | output | 1 | One-clock pulse when rd_data is valid |
| isa_sa | output | 16 | Bus address lines |
| isa_bale | output | 1 | Address latch strobe, active high |
| isa_aen | output | 1 | Address enable, high for DMA/refresh cycles |
| isa_ior_n | output | 1 | I/O read command, active low |
| isa_oe | output | 1 | Output enable for the bus drivers, low in reset |
| isa_iochrdy | input | 1 | Slave ready, low requests wait states |
| isa_iocs16_n | input | 1 | Slave 16-bit support, active low |
| isa_sd | input | 16 | Bus data from the slave |

## Verification
Two events can fall in the same cycle: the done pulse of a finishing read and a fresh start request. The bench provokes this by raising req_start at the sample point where it first sees rd_done high, so the start is sampled in the done clock. A second start is also placed in the middle of the command phase. Each case is judged at the ports: isa_sa must stay unchanged, exactly one done pulse must appear, and the latch strobe must stay low for several clocks after recovery.

// File: rtl/isa_io_reader.sv
module isa_io_reader #(
  parameter int ADDR_CLKS  = 2,
  parameter int CMD_CLKS   = 3,
  parameter int RECOV_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic [15:0] req_addr,
  input  logic        req_dma,
  output logic [15:0] rd_data,
  output logic        rd_done,
  output logic [15:0] isa_sa,
  output logic        isa_bale,
  output logic        isa_aen,
  output logic        isa_ior_n,
  output logic        isa_oe,
  input  logic        isa_iochrdy,
  input  logic        isa_iocs16_n,
  input  logic [15:0] isa_sd
);

  localparam int MAXC  = (ADDR_CLKS > CMD_CLKS) ? ((ADDR_CLKS > RECOV_CLKS) ? ADDR_CLKS : RECOV_CLKS)
                                                : ((CMD_CLKS > RECOV_CLKS) ? CMD_CLKS : RECOV_CLKS);
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WAIT, S_RECOV} phase_t;

  phase_t           st;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      addr_q;
  logic             dma_q;
  logic             oe_q;
  logic             busy;
  logic             in_cmd;
  logic             capture;

  assign busy    = (st != S_IDLE);
  assign in_cmd  = (st == S_CMD) || (st == S_WAIT);
  assign capture = isa_iochrdy && (((st == S_CMD) && (cnt == '0)) || (st == S_WAIT));

  assign isa_oe    = oe_q;
  assign isa_sa    = addr_q;
  assign isa_aen   = dma_q && busy;
  assign isa_bale  = (st == S_ADDR) || (dma_q && busy);
  assign isa_ior_n = !in_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      dma_q   <= 1'b0;
      rd_data <= '0;
      rd_done <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      oe_q    <= 1'b1;
      rd_done <= 1'b0;
      if (capture) begin
        rd_data <= isa_iocs16_n ? {8'h00, isa_sd[7:0]} : isa_sd;
        rd_done <= 1'b1;
        cnt     <= CNT_W'(RECOV_CLKS - 1);
        st      <= S_RECOV;
      end else begin
        case (st)
          S_IDLE: if (req_start) begin
            addr_q <= req_addr;
            dma_q  <= req_dma;
            cnt    <= CNT_W'(ADDR_CLKS - 1);
            st     <= S_ADDR;
          end
          S_ADDR: if (cnt == '0) begin
            cnt <= CNT_W'(CMD_CLKS - 1);
            st  <= S_CMD;
          end else cnt <= cnt - 1'b1;
          S_CMD: if (cnt != '0) cnt <= cnt - 1'b1;
                 else st <= S_WAIT;
          S_WAIT: st <= S_WAIT;
          S_RECOV: if (cnt == '0) st <= S_IDLE;
                   else cnt <= cnt - 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  bale_before_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(isa_ior_n) |-> $past(isa_bale));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_ior_n && !$rose(isa_bale)) |-> $stable(isa_sa));

  // R4
  dma_bale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_aen && !isa_ior_n) |-> isa_bale);

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_ior_n && !isa_iochrdy) |=> !isa_ior_n);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  // R6
  done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (isa_ior_n && $past(!isa_ior_n)));

  // R7
  narrow_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && $past(isa_iocs16_n)) |-> (rd_data[15:8] == 8'h00));

endmodule

// File: tb/tb_isa_io_reader.sv
`timescale 1ns/1ps
module tb_isa_io_reader;
  localparam int A = 2, C = 3, RC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_dma = 1'b0;
  logic [15:0] rd_data;
  logic        rd_done;
  logic [15:0] isa_sa;
  logic        isa_bale, isa_aen, isa_ior_n, isa_oe;
  logic        isa_iochrdy = 1'b1;
  logic        isa_iocs16_n = 1'b1;
  logic [15:0] isa_sd = 16'h5A5A;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  isa_io_reader #(.ADDR_CLKS(A), .CMD_CLKS(C), .RECOV_CLKS(RC)) dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_dma(req_dma), .rd_data(rd_data), .rd_done(rd_done), .isa_sa(isa_sa),
    .isa_bale(isa_bale), .isa_aen(isa_aen), .isa_ior_n(isa_ior_n), .isa_oe(isa_oe),
    .isa_iochrdy(isa_iochrdy), .isa_iocs16_n(isa_iocs16_n), .isa_sd(isa_sd));

  always #5 clk = ~clk;

  // {addr, dma, cs16, waits[3:0], data, expected}
  localparam int NV = 6;
  localparam logic [53:0] VEC [NV] = '{
    {16'h0378, 1'b0, 1'b0, 4'd0, 16'hA5C3, 16'h00C3},
    {16'h01F0, 1'b0, 1'b1, 4'd0, 16'h1234, 16'h1234},
    {16'h02F8, 1'b0, 1'b1, 4'd3, 16'hBEEF, 16'hBEEF},
    {16'h0060, 1'b1, 1'b0, 4'd1, 16'h7E81, 16'h0081},
    {16'hFFFF, 1'b1, 1'b1, 4'd0, 16'hFFFF, 16'hFFFF},
    {16'h0000, 1'b0, 1'b0, 4'd5, 16'h8001, 16'h0001}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_cycle(input logic [15:0] addr, input bit dma, input bit cs16,
                           input int waits, input logic [15:0] data,
                           input logic [15:0] exp, input bit poke);
    int bale_n = 0, low_n = 0, done_n = 0, iters = 0;
    bit aen_bad = 0, sa_bad = 0, done_seen = 0, gap_bad = 0, poked_mid = 0;
    logic [15:0] got = '0;
    @(negedge clk);
    req_addr = addr; req_dma = dma; req_start = 1'b1;
    isa_iocs16_n = !cs16;
    @(negedge clk);
    req_start = 1'b0;
    forever begin
      if (isa_bale) bale_n++;
      if (isa_bale || !isa_ior_n) begin
        if (isa_aen !== dma) aen_bad = 1;
        if (isa_sa !== addr) sa_bad = 1;
      end
      if (!isa_ior_n) begin
        low_n++;
        isa_sd = data;
        isa_iochrdy = (low_n >= C + waits);
      end else begin
        isa_sd = 16'h5A5A;
        isa_iochrdy = 1'b1;
      end
      req_start = 1'b0;
      if (poke && !isa_ior_n && !poked_mid) begin
        poked_mid = 1; req_start = 1'b1; req_addr = ~addr; req_dma = !dma;
      end
      if (rd_done) begin
        done_n++; done_seen = 1; got = rd_data;
        if (poke) begin req_start = 1'b1; req_addr = ~addr; end
      end
      if (done_seen && !isa_bale && isa_ior_n && !isa_aen) break;
      iters++;
      if (iters > 100) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (isa_bale || !isa_ior_n) gap_bad = 1;
      if (rd_done) done_n++;
      if (isa_sa !== addr) sa_bad = 1;
      @(negedge clk);
    end
    check(iters <= 100, "R6 cycle completes", iters, 100);
    check(got === exp, "R6/R7 read data", got, exp);
    check(done_n == 1, "R6 single done pulse", done_n, 1);
    check(low_n == C + waits, "R5 IOR# low clocks", low_n, C + waits);
    check(!aen_bad, "R3 AEN level", aen_bad, 0);
    check(!sa_bad, "R2 address held", sa_bad, 0);
    if (dma) check(bale_n == A + C + waits + RC, "R4 BALE over DMA cycle", bale_n, A + C + waits + RC);
    else     check(bale_n == A, "R2 BALE width", bale_n, A);
    if (poke) check(!gap_bad, "R8 start ignored while busy", gap_bad, 0);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(isa_oe === 1'b0, "R1 oe low in reset", isa_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(isa_oe === 1'b1 && isa_aen === 1'b0 && isa_bale === 1'b0 &&
          isa_ior_n === 1'b1 && rd_done === 1'b0, "R1 idle levels after reset",
          {isa_oe, isa_aen, isa_bale, isa_ior_n, rd_done}, 5'b10010);

    for (int i = 0; i < NV; i++)
      run_cycle(VEC[i][53:38], VEC[i][37], VEC[i][36], int'(VEC[i][35:32]),
                VEC[i][31:16], VEC[i][15:0], 1'b0);

    // R8: start in mid-command and in the done clock, io then dma
    run_cycle(16'h03F8, 1'b0, 1'b1, 2, 16'hC0DE, 16'hC0DE, 1'b1);
    run_cycle(16'h0278, 1'b1, 1'b0, 0, 16'h4455, 16'h0055, 1'b1);

    // R1: reset mid-cycle returns to idle with outputs disabled
    @(negedge clk);
    req_addr = 16'h0100; req_dma = 1'b1; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    rst_n = 1'b0;
    #1;
    check(isa_oe === 1'b0 && isa_aen === 1'b0 && isa_ior_n === 1'b1,
          "R1 reset during cycle", {isa_oe, isa_aen, isa_ior_n}, 3'b001);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(isa_oe === 1'b1 && isa_bale === 1'b0 && isa_aen === 1'b0,
          "R1 idle after second reset", {isa_oe, isa_bale, isa_aen}, 3'b100);

    finish_run();
  end
endmodule